// File: doc/BRIEF.md
# Indirect Branch Target Predictor

This block guesses where an indirect branch will jump. For each resolved branch it receives the branch address and the target the branch really went to. It reads the target remembered for that branch and reports it as the prediction. It flags a mispredict when the remembered target is not the real one. It then records the real target in place of the old one.

The table is direct-mapped and carries no tags. Each entry is picked by a slice of the branch address, so every branch that maps to an entry shares it with the others. There is no confidence counter, and every event replaces the entry. After reset the block sweeps the whole table to zero and raises `ready` once the sweep is done. Results appear in the cycle after the event. An event that follows straight on from one to the same entry sees the target that was just recorded, through a bypass around the table.

Top module: `tgt_pred`

## Requirements
- R1: After reset is released, `ready` stays low for exactly 2^IDX_W cycles while every entry is written to zero. It then goes high and stays high until the next reset, and `res_valid` is low for the whole sweep.
- R2: An event presented while `ready` is low produces no result and leaves the table unchanged.
- R3: An event accepted in cycle t (`evt_valid` and `ready` both high) raises `res_valid` in cycle t+1 only. `res_valid` is low in any cycle that does not follow an accepted event.
- R4: The entry index is `evt_addr[LO_ZERO+IDX_W-1:LO_ZERO]`. Addresses that differ only below bit LO_ZERO or above that slice use the same entry.
- R5: `res_pred` is the target the selected entry held before the event was applied. Every entry holds zero after the reset sweep.
- R6: `res_mispredict` is 1 exactly when `res_pred` differs from the event's `evt_target`, and is 0 when `res_valid` is low.
- R7: Every accepted event writes its `evt_target` into its entry, whether it was predicted correctly or not. A second event to that entry with the same target therefore reports a hit.
- R8: When two accepted events in consecutive cycles select the same entry, the second one's `res_pred` is the first one's `evt_target`.
- R9: A reset asserted in the middle of operation clears all previously recorded targets again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the clearing sweep |
| evt_valid | input | 1 | A resolved indirect branch is presented this cycle |
| evt_addr | input | ADDR_W | Address of the branch |
| evt_target | input | TGT_W | Target the branch actually went to |
| ready | output | 1 | Table is cleared and events are accepted |
| res_valid | output | 1 | Result for the event accepted in the previous cycle |
| res_pred | output | TGT_W | Target that was predicted for that event |
| res_mispredict | output | 1 | Predicted target differed from the actual one |

## Verification
The bench builds the block with its defaults: 32-bit addresses and targets, a 512-entry table and two always-zero low address bits. With 512 entries the clearing sweep is short enough to run twice, once at start-up and once after a reset in mid-run. Random addresses are confined to eight entries and carry random bits below and above the index slice. This makes aliasing, repeated targets and back-to-back events to the same entry frequent, so the bypass path and the always-overwrite rule are exercised many times.

// File: rtl/tgt_pred_pkg.sv
package tgt_pred_pkg;

    localparam int unsigned DEF_ADDR_W  = 32;
    localparam int unsigned DEF_TGT_W   = 32;
    localparam int unsigned DEF_IDX_W   = 9;
    localparam int unsigned DEF_LO_ZERO = 2;

    typedef enum logic [0:0] {
        SWEEP_CLEAR = 1'b0,
        SWEEP_DONE  = 1'b1
    } sweep_state_e;

endpackage

// File: rtl/tgt_pred_sweep.sv
module tgt_pred_sweep
    import tgt_pred_pkg::*;
#(
    parameter int unsigned IDX_W = DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    output logic             clr_we,
    output logic [IDX_W-1:0] clr_idx,
    output logic             ready
);

    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    sweep_state_e     state_q;
    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SWEEP_CLEAR;
            cnt_q   <= '0;
        end else if (state_q == SWEEP_CLEAR) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_IDX) begin
                state_q <= SWEEP_DONE;
            end
        end
    end

    assign clr_we  = (state_q == SWEEP_CLEAR);
    assign clr_idx = cnt_q;
    assign ready   = (state_q == SWEEP_DONE);

    // R1: once up, ready holds until reset
    p_ready_holds_r1: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R1: ready only rises after the last entry was written
    p_sweep_complete_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(clr_idx) == LAST_IDX && $past(clr_we)));

endmodule

// File: rtl/tgt_pred_store.sv
module tgt_pred_store
    import tgt_pred_pkg::*;
#(
    parameter int unsigned IDX_W = DEF_IDX_W,
    parameter int unsigned TGT_W = DEF_TGT_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TGT_W-1:0] wr_data,
    input  logic             re,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TGT_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [TGT_W-1:0] mem [DEPTH];
    logic [TGT_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_idx] <= wr_data;
        end
        if (re) begin
            rd_q <= mem[rd_idx];
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/tgt_pred.sv
module tgt_pred
    import tgt_pred_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned TGT_W   = DEF_TGT_W,
    parameter int unsigned IDX_W   = DEF_IDX_W,
    parameter int unsigned LO_ZERO = DEF_LO_ZERO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [TGT_W-1:0]  evt_target,
    output logic              ready,
    output logic              res_valid,
    output logic [TGT_W-1:0]  res_pred,
    output logic              res_mispredict
);

    localparam int unsigned IDX_HI = LO_ZERO + IDX_W - 1;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [TGT_W-1:0] tgt;
    } stage_t;

    typedef struct packed {
        logic             hit;
        logic [TGT_W-1:0] data;
    } bypass_t;

    logic             accept;
    logic [IDX_W-1:0] evt_idx;
    stage_t           s1_q;
    bypass_t          byp_q;
    logic             clr_we;
    logic [IDX_W-1:0] clr_idx;
    logic             st_we;
    logic [IDX_W-1:0] st_wr_idx;
    logic [TGT_W-1:0] st_wr_data;
    logic [TGT_W-1:0] st_rd_data;
    logic [TGT_W-1:0] pred_sel;

    assign evt_idx = evt_addr[IDX_HI:LO_ZERO];
    assign accept  = evt_valid && ready;

    tgt_pred_sweep #(.IDX_W(IDX_W)) sweep_i (
        .clk     (clk),
        .rst     (rst),
        .clr_we  (clr_we),
        .clr_idx (clr_idx),
        .ready   (ready)
    );

    // clearing and event writes never overlap: events wait for ready
    assign st_we      = clr_we || s1_q.vld;
    assign st_wr_idx  = clr_we ? clr_idx : s1_q.idx;
    assign st_wr_data = clr_we ? '0 : s1_q.tgt;

    tgt_pred_store #(.IDX_W(IDX_W), .TGT_W(TGT_W)) store_i (
        .clk     (clk),
        .we      (st_we),
        .wr_idx  (st_wr_idx),
        .wr_data (st_wr_data),
        .re      (accept),
        .rd_idx  (evt_idx),
        .rd_data (st_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q  <= '0;
            byp_q <= '0;
        end else begin
            s1_q.vld <= accept;
            if (accept) begin
                s1_q.idx   <= evt_idx;
                s1_q.tgt   <= evt_target;
                byp_q.hit  <= s1_q.vld && (s1_q.idx == evt_idx);
                byp_q.data <= s1_q.tgt;
            end
        end
    end

    assign pred_sel       = byp_q.hit ? byp_q.data : st_rd_data;
    assign res_valid      = s1_q.vld;
    assign res_pred       = pred_sel;
    assign res_mispredict = s1_q.vld && (pred_sel != s1_q.tgt);

    // R2: nothing comes out while the table is being cleared
    p_quiet_while_clear_r2: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !res_valid);

    // R3: an accepted event gives a result in the next cycle
    p_result_follows_r3: assert property (@(posedge clk) disable iff (rst)
        accept |=> res_valid);

    // R3: no result without an accepted event one cycle earlier
    p_no_spurious_result_r3: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(accept));

    // R6: mispredict matches comparison with the event's target
    p_miss_meaning_r6: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_mispredict == (res_pred != $past(evt_target))));

    // R6: no mispredict without a result
    p_miss_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_mispredict);

    // R8: back-to-back same entry sees the previous event's target
    p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && s1_q.vld && (s1_q.idx == evt_idx)) |=> (res_pred == $past(s1_q.tgt)));

endmodule

// File: tb/tgt_pred_tb_top.sv
`timescale 1ns/1ps
module tgt_pred_tb_top;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned TGT_W   = 32;
    localparam int unsigned IDX_W   = 9;
    localparam int unsigned LO_ZERO = 2;
    localparam int unsigned DEPTH   = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              evt_valid = 1'b0;
    logic [ADDR_W-1:0] evt_addr = '0;
    logic [TGT_W-1:0]  evt_target = '0;
    logic              ready;
    logic              res_valid;
    logic [TGT_W-1:0]  res_pred;
    logic              res_mispredict;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    logic [TGT_W-1:0] model [DEPTH];

    always #2 clk = ~clk;

    tgt_pred #(
        .ADDR_W(ADDR_W), .TGT_W(TGT_W), .IDX_W(IDX_W), .LO_ZERO(LO_ZERO)
    ) dut_i (
        .clk            (clk),
        .rst            (rst),
        .evt_valid      (evt_valid),
        .evt_addr       (evt_addr),
        .evt_target     (evt_target),
        .ready          (ready),
        .res_valid      (res_valid),
        .res_pred       (res_pred),
        .res_mispredict (res_mispredict)
    );

    function automatic int unsigned idx_of(logic [ADDR_W-1:0] a);
        return int'((a >> LO_ZERO) & (DEPTH - 1));
    endfunction

    task automatic chk(string req, logic [TGT_W-1:0] act, logic [TGT_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drives one cycle (called at a negedge) and checks its result at the next negedge
    task automatic step(string req, logic v, logic [ADDR_W-1:0] a, logic [TGT_W-1:0] t);
        logic             exp_v;
        logic [TGT_W-1:0] exp_p;
        exp_v = v && ready;
        exp_p = '0;
        if (exp_v) begin
            exp_p = model[idx_of(a)];
            model[idx_of(a)] = t;
        end
        evt_valid  = v;
        evt_addr   = a;
        evt_target = t;
        @(negedge clk);
        evt_valid = 1'b0;
        chk(req, {31'd0, res_valid}, {31'd0, exp_v});
        if (exp_v) begin
            chk(req, res_pred, exp_p);
            chk(req, {31'd0, res_mispredict}, {31'd0, (exp_p != t)});
        end else begin
            chk(req, {31'd0, res_mispredict}, 32'd0);
        end
    endtask

    task automatic do_reset(logic inject);
        int unsigned n;
        rst = 1'b1;
        evt_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", {31'd0, ready}, 32'd0);
        chk("R1", {31'd0, res_valid}, 32'd0);
        for (int i = 0; i < int'(DEPTH); i++) model[i] = '0;
        rst = 1'b0;
        n = 0;
        while (!ready && n < 4000) begin
            if (inject && n == 5) begin
                evt_valid  = 1'b1;
                evt_addr   = 32'h0000_0100;
                evt_target = 32'h0000_DEAD;
            end else begin
                evt_valid = 1'b0;
            end
            @(negedge clk);
            n++;
            if (inject && n == 6) chk("R2", {31'd0, res_valid}, 32'd0);
            if (!ready) chk("R1", {31'd0, res_valid}, 32'd0);
        end
        evt_valid = 1'b0;
        chk("R1", n, DEPTH);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset(1'b1);

        // R2: the event during clearing left entry 0x40 at zero
        step("R2", 1'b1, 32'h0000_0100, 32'h0000_1234);
        // R5: fresh entry with target zero is a hit
        step("R5", 1'b1, 32'h0000_0200, 32'h0000_0000);
        step("R3", 1'b0, 32'h0000_0100, 32'h0000_9999);
        // R7: the recorded target is now predicted
        step("R7", 1'b1, 32'h0000_0100, 32'h0000_1234);
        step("R3", 1'b0, 32'h0, 32'h0);
        step("R7", 1'b1, 32'h0000_0100, 32'h0000_1234);
        // R4: low bits and bits above the slice alias
        step("R4", 1'b1, 32'h0000_0901, 32'h0000_0055);
        step("R3", 1'b0, 32'h0, 32'h0);
        step("R4", 1'b1, 32'h0000_0103, 32'h0000_0066);
        step("R4", 1'b1, 32'h0000_0104, 32'h0000_0077);
        // R8: back-to-back events to the same entry
        step("R8", 1'b1, 32'h0000_0300, 32'h0000_000A);
        step("R8", 1'b1, 32'h0000_0300, 32'h0000_000B);
        step("R8", 1'b1, 32'h0000_0302, 32'h0000_000B);
        step("R8", 1'b1, 32'h0000_0304, 32'h0000_000C);
        step("R8", 1'b1, 32'h0000_0300, 32'h0000_000D);

        // R6: random traffic over few entries with aliasing bits
        for (int k = 0; k < 2500; k++) begin
            logic [ADDR_W-1:0] a;
            logic [TGT_W-1:0]  t;
            logic              v;
            v = ($urandom % 5) != 0;
            a = ((32'($urandom % 8)) << LO_ZERO) | 32'($urandom % 4)
                | ((32'($urandom % 4)) << (LO_ZERO + IDX_W));
            t = 32'($urandom % 4) << 12;
            step("R6", v, a, t);
        end

        // R9: reset in mid-operation forgets recorded targets
        step("R9", 1'b1, 32'h0000_0100, 32'h0000_4321);
        do_reset(1'b0);
        step("R9", 1'b1, 32'h0000_0100, 32'h0000_4321);
        step("R9", 1'b1, 32'h0000_0300, 32'h0000_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule